// File: doc/BRIEF.md
# CPU System Register File

This block holds the CPU's control registers and hands them to the rest of the core through a 5-bit register number. A load port writes a register on the next clock edge. A store port returns a register's value combinationally from the number presented to it. The program counter is only an input. It has no number and no port can read or write it.

Four kinds of event each copy the current program counter and the current status word into their own save pair:
- a maskable interrupt,
- a non-maskable interrupt,
- a table call,
- a debug trap.

A debug trap is raised by either of two detect inputs: the illegal-opcode input or the ROM-correction input. On a debug trap the block also gives the handler entry address as a redirect target. It then opens a debug window, which stays open until the debug return strobe. The debug save pair can be loaded or stored only while that window is open.

Top module: `sysreg_file`

## Requirements
- R1: Register numbers 0, 1, 2, 3, 4, 5, 16, 17, 18, 19 and 20 are 32-bit registers. A load to one of them (18 and 19 only while the window is open) changes the value read at the next clock edge. A store read returns the current value combinationally.
- R2: Numbers 6 to 15 and 21 to 31 are reserved. A load to them changes no register, and a store read of them returns 0.
- R3: Each event copies pc_i into the PC register of its pair and the pre-edge status word (number 5) into the PSW register of its pair. A maskable interrupt uses 0/1, a non-maskable interrupt uses 2/3 and a table call uses 16/17.
- R4: Either detect input (illegal opcode or ROM correction) is a debug trap. A debug trap saves pc_i and the pre-edge status word into 18/19.
- R5: When an event save and a load hit the same register in one cycle, the event value is stored.
- R6: The debug window opens at the edge after a debug trap and closes at the edge after a debug return. A trap wins when both occur together. Reset closes the window.
- R7: While the debug window is closed, store reads of 18 and 19 return 0 and loads to them are ignored.
- R8: redirect_valid_o is high in exactly the cycles in which a debug trap input is high, and redirect_pc_o is then 0x0000_0060.
- R9: After reset every register reads 0 except the status word (number 5), which reads PSW_RST (default 0x0000_0020).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Load (write) strobe |
| ld_id_i | input | 5 | Register number of the load |
| ld_data_i | input | 32 | Load data |
| st_id_i | input | 5 | Register number of the store read |
| st_data_o | output | 32 | Store read data, combinational |
| pc_i | input | 32 | Current program counter |
| ev_int_i | input | 1 | Maskable interrupt taken |
| ev_nmi_i | input | 1 | Non-maskable interrupt taken |
| ev_call_i | input | 1 | Table call executed |
| ilop_det_i | input | 1 | Illegal-opcode detect (debug trap) |
| romc_det_i | input | 1 | ROM-correction detect (debug trap) |
| dbg_ret_i | input | 1 | Debug return executed |
| dbg_win_o | output | 1 | Debug window open |
| redirect_valid_o | output | 1 | Redirect to the debug handler |
| redirect_pc_o | output | 32 | Debug handler entry address |

## Verification
A wrong internal state shows up at the store port. The bench reads a register number every cycle, so a corrupted register, a missed save or a wrong save priority appears as a mismatch on st_data_o in the cycle after the faulty edge. A stuck or mis-timed debug window shows in two places: on dbg_win_o one cycle after the trap or return edge, and as unexpected zero or non-zero data when 18 or 19 is read. Reserved-number decoding is covered by random reads and writes across all 32 numbers, and each write is read back in a later cycle.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int unsigned ID_W   = 5;
  localparam int unsigned NSLOT  = 11;
  localparam int unsigned SLOT_W = $clog2(NSLOT);

  // storage slot order
  typedef enum logic [SLOT_W-1:0] {
    S_IPC  = 4'd0, S_IPSW = 4'd1, S_NPC  = 4'd2, S_NPSW = 4'd3,
    S_SRC  = 4'd4, S_PSW  = 4'd5, S_CPC  = 4'd6, S_CPSW = 4'd7,
    S_DPC  = 4'd8, S_DPSW = 4'd9, S_CBAS = 4'd10
  } slot_e;

  function automatic logic id_valid(input logic [ID_W-1:0] id);
    return (id <= 5'd5) || (id >= 5'd16 && id <= 5'd20);
  endfunction

  function automatic logic id_gated(input logic [ID_W-1:0] id);
    return (id == 5'd18) || (id == 5'd19);
  endfunction

  function automatic logic [SLOT_W-1:0] id_to_slot(input logic [ID_W-1:0] id);
    logic [ID_W-1:0] s;
    s = (id <= 5'd5) ? id : id - 5'd10;
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [ID_W-1:0]   id_i,
  input  logic              win_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              hit_o
);
  always_comb begin
    slot_o = id_to_slot(id_i);
    hit_o  = id_valid(id_i) && (!id_gated(id_i) || win_i);
  end
endmodule

// File: rtl/sysreg_cell.sv
module sysreg_cell #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         save_i,
  input  logic [W-1:0] save_data_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST;
    else if (save_i) q_o <= save_data_i;  // event beats load
    else if (wr_i)   q_o <= wr_data_i;
  end
endmodule

// File: rtl/sysreg_dbg_win.sv
module sysreg_dbg_win (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trap_i,
  input  logic ret_i,
  output logic win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_o <= 1'b0;
    else if (trap_i) win_o <= 1'b1;
    else if (ret_i)  win_o <= 1'b0;
  end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int unsigned   XLEN    = 32,
  parameter logic [XLEN-1:0] PSW_RST = 32'h0000_0020,
  parameter logic [XLEN-1:0] DBG_VEC = 32'h0000_0060
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_en_i,
  input  logic [4:0]      ld_id_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic [4:0]      st_id_i,
  output logic [XLEN-1:0] st_data_o,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ev_int_i,
  input  logic            ev_nmi_i,
  input  logic            ev_call_i,
  input  logic            ilop_det_i,
  input  logic            romc_det_i,
  input  logic            dbg_ret_i,
  output logic            dbg_win_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  logic [NSLOT-1:0][XLEN-1:0] reg_q;
  logic [NSLOT-1:0]           save;
  logic [NSLOT-1:0][XLEN-1:0] save_data;
  logic [SLOT_W-1:0]          wr_slot, rd_slot;
  logic                       wr_hit, rd_hit, dbg_trap;

  assign dbg_trap = ilop_det_i | romc_det_i;

  sysreg_dbg_win u_win (
    .clk_i, .rst_ni, .trap_i(dbg_trap), .ret_i(dbg_ret_i), .win_o(dbg_win_o)
  );

  sysreg_decode u_wr_dec (.id_i(ld_id_i), .win_i(dbg_win_o), .slot_o(wr_slot), .hit_o(wr_hit));
  sysreg_decode u_rd_dec (.id_i(st_id_i), .win_i(dbg_win_o), .slot_o(rd_slot), .hit_o(rd_hit));

  always_comb begin
    save = '0;
    save[S_IPC]  = ev_int_i;  save[S_IPSW] = ev_int_i;
    save[S_NPC]  = ev_nmi_i;  save[S_NPSW] = ev_nmi_i;
    save[S_CPC]  = ev_call_i; save[S_CPSW] = ev_call_i;
    save[S_DPC]  = dbg_trap;  save[S_DPSW] = dbg_trap;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_reg
    localparam logic [XLEN-1:0] RV = (g == S_PSW) ? PSW_RST : '0;
    localparam bit IS_PSW_SAVE = (g == S_IPSW) || (g == S_NPSW) ||
                                 (g == S_CPSW) || (g == S_DPSW);
    assign save_data[g] = IS_PSW_SAVE ? reg_q[S_PSW] : pc_i;
    sysreg_cell #(.W(XLEN), .RST(RV)) u_cell (
      .clk_i, .rst_ni,
      .save_i     (save[g]),
      .save_data_i(save_data[g]),
      .wr_i       (ld_en_i && wr_hit && (wr_slot == SLOT_W'(g))),
      .wr_data_i  (ld_data_i),
      .q_o        (reg_q[g])
    );
  end

  assign st_data_o        = rd_hit ? reg_q[rd_slot] : '0;
  assign redirect_valid_o = dbg_trap;
  assign redirect_pc_o    = DBG_VEC;
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk
  import sysreg_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [4:0]                 st_id_i,
  input logic [XLEN-1:0]            st_data_o,
  input logic [XLEN-1:0]            pc_i,
  input logic                       ev_int_i,
  input logic                       ev_nmi_i,
  input logic                       ilop_det_i,
  input logic                       romc_det_i,
  input logic                       dbg_ret_i,
  input logic                       dbg_win_o,
  input logic                       redirect_valid_o,
  input logic [XLEN-1:0]            redirect_pc_o,
  input logic [NSLOT-1:0][XLEN-1:0] reg_q
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid(st_id_i) |-> st_data_o == '0);

  a_r7_gate_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_win_o && id_gated(st_id_i)) |-> st_data_o == '0);

  a_r3_int_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_int_i |=> (reg_q[S_IPC] == $past(pc_i)) && (reg_q[S_IPSW] == $past(reg_q[S_PSW])));

  a_r3_nmi_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_nmi_i |=> (reg_q[S_NPC] == $past(pc_i)) && (reg_q[S_NPSW] == $past(reg_q[S_PSW])));

  a_r4_trap_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilop_det_i || romc_det_i) |=> reg_q[S_DPC] == $past(pc_i));

  a_r6_win_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilop_det_i || romc_det_i) |=> dbg_win_o);

  a_r6_win_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ret_i && !ilop_det_i && !romc_det_i) |=> !dbg_win_o);

  a_r8_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> redirect_pc_o == 32'h0000_0060);

  a_r8_redirect_when: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o == (ilop_det_i || romc_det_i));
endmodule

bind sysreg_file sysreg_chk #(.XLEN(XLEN)) u_chk (
  .clk_i, .rst_ni, .st_id_i, .st_data_o, .pc_i, .ev_int_i, .ev_nmi_i,
  .ilop_det_i, .romc_det_i, .dbg_ret_i, .dbg_win_o, .redirect_valid_o,
  .redirect_pc_o, .reg_q
);

// File: tb/test_sysreg_file.sv
module test_sysreg_file;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PSW_RST = 32'h0000_0020;

  logic        clk_i = 0, rst_ni = 0;
  logic        ld_en_i = 0;
  logic [4:0]  ld_id_i = 0, st_id_i = 0;
  logic [31:0] ld_data_i = 0, pc_i = 0;
  logic        ev_int_i = 0, ev_nmi_i = 0, ev_call_i = 0;
  logic        ilop_det_i = 0, romc_det_i = 0, dbg_ret_i = 0;
  logic [31:0] st_data_o, redirect_pc_o;
  logic        dbg_win_o, redirect_valid_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_reg [32];
  logic        m_win;

  sysreg_file i_sysreg_file (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic bit valid_id(input int id);
    return (id <= 5) || (id >= 16 && id <= 20);
  endfunction

  function automatic logic [31:0] exp_read(input int id);
    if (!valid_id(id)) return 0;
    if ((id == 18 || id == 19) && !m_win) return 0;
    return m_reg[id];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // model of the next edge, from current inputs
  task automatic model_edge();
    logic [31:0] psw_old;
    bit trap;
    psw_old = m_reg[5];
    trap = ilop_det_i | romc_det_i;
    if (ld_en_i && valid_id(ld_id_i) && (!(ld_id_i == 18 || ld_id_i == 19) || m_win))
      m_reg[ld_id_i] = ld_data_i;
    if (ev_int_i)  begin m_reg[0]  = pc_i; m_reg[1]  = psw_old; end
    if (ev_nmi_i)  begin m_reg[2]  = pc_i; m_reg[3]  = psw_old; end
    if (ev_call_i) begin m_reg[16] = pc_i; m_reg[17] = psw_old; end
    if (trap)      begin m_reg[18] = pc_i; m_reg[19] = psw_old; end
    if (trap) m_win = 1;
    else if (dbg_ret_i) m_win = 0;
  endtask

  // inputs set after negedge; read checked; edge; model updated
  task automatic cycle(input string req);
    #1;
    check(req, st_data_o, exp_read(st_id_i));
    check("R8", {31'b0, redirect_valid_o}, {31'b0, ilop_det_i | romc_det_i});
    if (redirect_valid_o) check("R8", redirect_pc_o, 32'h0000_0060);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check("R6", {31'b0, dbg_win_o}, {31'b0, m_win});
  endtask

  task automatic idle();
    ld_en_i = 0; ev_int_i = 0; ev_nmi_i = 0; ev_call_i = 0;
    ilop_det_i = 0; romc_det_i = 0; dbg_ret_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    m_reg[5] = PSW_RST;
    m_win = 0;
    #(CLK_PERIOD * 2 + 2);
    rst_ni = 1;
    @(negedge clk_i);

    // R9 reset state
    for (int i = 0; i < 32; i++) begin
      st_id_i = 5'(i); #1;
      check("R9", st_data_o, (i == 5) ? PSW_RST : 32'h0);
    end
    check("R6", {31'b0, dbg_win_o}, 32'h0);

    // R1 write/readback of every valid id
    for (int i = 0; i < 32; i++) begin
      ld_en_i = 1; ld_id_i = 5'(i); ld_data_i = 32'hA500_0000 + i; st_id_i = 5'(i);
      cycle((i == 18 || i == 19) ? "R7" : (valid_id(i) ? "R1" : "R2"));
      ld_en_i = 0; cycle((i == 18 || i == 19) ? "R7" : (valid_id(i) ? "R1" : "R2"));
    end

    // R5 event beats load on same register
    ld_en_i = 1; ld_id_i = 0; ld_data_i = 32'hDEAD_BEEF; pc_i = 32'h0000_1234; ev_int_i = 1;
    st_id_i = 0; cycle("R5");
    idle(); cycle("R5");
    check("R5", st_data_o, 32'h0000_1234);

    // R4/R6 trap via ROM correction, then R7 access inside window
    romc_det_i = 1; pc_i = 32'h0000_4440; st_id_i = 18; cycle("R4");
    idle(); cycle("R4");
    check("R4", st_data_o, 32'h0000_4440);
    ld_en_i = 1; ld_id_i = 19; ld_data_i = 32'h1357_9BDF; st_id_i = 19; cycle("R7");
    idle(); cycle("R7");
    // trap and return together: trap wins
    ilop_det_i = 1; dbg_ret_i = 1; cycle("R6");
    idle(); dbg_ret_i = 1; cycle("R6");
    idle(); st_id_i = 18; cycle("R7");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      ld_en_i    = ($urandom_range(0, 1) == 1);
      ld_id_i    = 5'($urandom_range(0, 31));
      ld_data_i  = $urandom;
      st_id_i    = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(18, 19)) : 5'($urandom_range(0, 31));
      pc_i       = $urandom & 32'hFFFF_FFFE;
      ev_int_i   = ($urandom_range(0, 9) == 0);
      ev_nmi_i   = ($urandom_range(0, 14) == 0);
      ev_call_i  = ($urandom_range(0, 9) == 0);
      ilop_det_i = ($urandom_range(0, 29) == 0);
      romc_det_i = ($urandom_range(0, 39) == 0);
      dbg_ret_i  = ($urandom_range(0, 19) == 0);
      cycle("R3");
    end
    idle();
    cycle("R1");
    finish_run();
  end
endmodule